// File: doc/BRIEF.md
# Early-Write Hazard Interlock

This block is the stall logic for a six-stage in-order integer pipeline made of fetch, decode, operand read, execute, memory and writeback. Most instructions update the register file in writeback. A load-immediate instruction sign-extends a 16-bit constant to 32 bits without the ALU and writes it from the decode stage. Because the pipeline has these two write points, the interlock must catch write-after-write hazards and, depending on how the register file orders its reads and writes, write-after-read hazards, in addition to the usual read-after-write hazards.

The block is purely combinational. It receives each stage's valid bit, destination identifier, write flag and a marker for load-immediate instructions. From the operand-read stage it also receives the two source identifiers. It drives one stall line, which holds fetch and decode and puts a bubble into operand read. It also drives the gated enable for the decode-stage write port. The parameter `WRITE_FIRST` selects the register-file ordering: 1 means writes land before reads in the same cycle, and 0 means reads happen first. Forwarding, the register file and the datapath sit outside this block.

Top module: `early_wr_interlock`

## Requirements
- R1: When decode holds a valid load-immediate, stall is high if its destination equals the destination of any stage in operand read, execute, memory or writeback that is valid, has its write flag at 1 and is not a load-immediate.
- R2: A stage whose load-immediate marker is 1 has already written its result, so it never causes a stall through its destination, neither for write-after-write nor for read-after-write.
- R3: With `WRITE_FIRST`=1, a valid load-immediate in decode whose destination equals source 1 or source 2 of a valid operand-read stage raises stall.
- R4: With `WRITE_FIRST`=0, the source-versus-decode-destination match of R3 does not raise stall.
- R5: When operand read is valid, stall is high if either source equals the destination of a valid, writing, non-load-immediate instruction in execute, memory or writeback.
- R6: Register identifier 0 never takes part in a match, either as a destination or as a source.
- R7: A stage whose valid bit is 0 or whose write flag is 0 is ignored as a producer. An invalid operand-read stage is ignored both as a reader and as a writer.
- R8: `id_rf_we` equals `id_valid` AND `id_ldi` AND NOT stall, so a stalled load-immediate does not write in that cycle and writes once when it is replayed.
- R9: With no match of the kinds above, stall is 0. A decode instruction that is not a load-immediate never raises stall through its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds an instruction |
| id_ldi | input | 1 | Decode instruction is a load-immediate |
| id_dst | input | REG_AW | Decode destination register |
| rr_valid | input | 1 | Operand-read stage holds an instruction |
| rr_we | input | 1 | Operand-read instruction writes a register |
| rr_ldi | input | 1 | Operand-read instruction is a load-immediate |
| rr_dst | input | REG_AW | Operand-read destination register |
| rr_src1 | input | REG_AW | First source register read in operand read |
| rr_src2 | input | REG_AW | Second source register read in operand read |
| ex_valid | input | 1 | Execute stage valid |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_ldi | input | 1 | Execute instruction is a load-immediate |
| ex_dst | input | REG_AW | Execute destination register |
| mem_valid | input | 1 | Memory stage valid |
| mem_we | input | 1 | Memory instruction writes a register |
| mem_ldi | input | 1 | Memory instruction is a load-immediate |
| mem_dst | input | REG_AW | Memory destination register |
| wb_valid | input | 1 | Writeback stage valid |
| wb_we | input | 1 | Writeback instruction writes a register |
| wb_ldi | input | 1 | Writeback instruction is a load-immediate |
| wb_dst | input | REG_AW | Writeback destination register |
| stall | output | 1 | Hold fetch and decode and insert a bubble |
| id_rf_we | output | 1 | Enable for the decode-stage register-file write port |

## Verification
The hardest case to reach is a load-immediate that collides with an older instruction which is itself a load-immediate. That older instruction has already written, so the match must be ignored. A real pipeline reaches this only when two constant loads to one register follow each other closely. The stimulus sets the marker and the matching destination directly in a single stage while leaving the other stages idle. It also reuses the same operand pattern in both register-file orderings at once, so the write-after-read split between the two is seen on one input vector.

// File: rtl/eh_pkg.sv
package eh_pkg;
   // producer stages below decode, oldest last
   typedef enum int {
      SG_RR  = 0,
      SG_EX  = 1,
      SG_MEM = 2,
      SG_WB  = 3
   } stage_idx_e;

   localparam int N_DOWN = 4;  // stages that can hold an older writer
   localparam int N_SRC  = 2;  // operands read in operand read

   // a producer is pending when it will still write in writeback
   function automatic logic pending_writer(input logic v, input logic we, input logic ldi);
      return v & we & ~ldi;
   endfunction
endpackage

// File: rtl/hz_match.sv
module hz_match #(
   parameter int AW = 5,
   parameter int N  = 4
) (
   input  logic                 key_en,
   input  logic [AW-1:0]        key,
   input  logic [N-1:0]         ent_live,
   input  logic [N-1:0][AW-1:0] ent_id,
   output logic                 hit
);
   if (AW < 1)
      begin : g_bad_aw
         $error("hz_match: AW must be at least 1");
      end
   if (N < 1)
      begin : g_bad_n
         $error("hz_match: N must be at least 1");
      end

   logic [N-1:0] eq_v;
   logic         hit_c;

   always_comb begin
      eq_v = '0;
      for (int i = 0; i < N; i++) begin
         eq_v[i] = key_en && ent_live[i] && (ent_id[i] == key) && (key != '0);
      end
      hit_c = |eq_v;
      if (hit_c) begin
         // R6: the zero register never produces a match
         a_r6_zero_never_hits: assert (key != '0)
            else $error("zero register matched");
         // R7: only a live entry may produce a match
         a_r7_hit_needs_live: assert (key_en && (ent_live != '0))
            else $error("match without live entry");
      end
   end

   assign hit = hit_c;
endmodule

// File: rtl/hz_war_sel.sv
module hz_war_sel #(
   parameter int AW          = 5,
   parameter int WRITE_FIRST = 1
) (
   input  logic          li_en,
   input  logic [AW-1:0] li_dst,
   input  logic          rd_valid,
   input  logic [AW-1:0] rd_src1,
   input  logic [AW-1:0] rd_src2,
   output logic          war
);
   if (WRITE_FIRST != 0)
      begin : g_write_first
         // early write lands before the older reader samples its operands
         hz_match #(.AW(AW), .N(eh_pkg::N_SRC)) u_war (
            .key_en   (li_en),
            .key      (li_dst),
            .ent_live ({rd_valid, rd_valid}),
            .ent_id   ({rd_src2, rd_src1}),
            .hit      (war)
         );
      end
   else
      begin : g_read_first
         // reader samples first: ordering makes the hazard impossible
         logic unused_war;
         assign unused_war = &{1'b0, li_en, li_dst, rd_valid, rd_src1, rd_src2};
         assign war = 1'b0;
      end
endmodule

// File: rtl/early_wr_interlock.sv
module early_wr_interlock #(
   parameter int REG_AW      = 5,
   parameter int WRITE_FIRST = 1
) (
   input  logic              id_valid,
   input  logic              id_ldi,
   input  logic [REG_AW-1:0] id_dst,
   input  logic              rr_valid,
   input  logic              rr_we,
   input  logic              rr_ldi,
   input  logic [REG_AW-1:0] rr_dst,
   input  logic [REG_AW-1:0] rr_src1,
   input  logic [REG_AW-1:0] rr_src2,
   input  logic              ex_valid,
   input  logic              ex_we,
   input  logic              ex_ldi,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              mem_valid,
   input  logic              mem_we,
   input  logic              mem_ldi,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              wb_valid,
   input  logic              wb_we,
   input  logic              wb_ldi,
   input  logic [REG_AW-1:0] wb_dst,
   output logic              stall,
   output logic              id_rf_we
);
   import eh_pkg::*;

   localparam int N_PROD = N_DOWN - 1;  // producers checked against operand reads

   if (REG_AW < 1 || REG_AW > 8)
      begin : g_bad_aw
         $error("early_wr_interlock: REG_AW out of range");
      end
   if (WRITE_FIRST != 0 && WRITE_FIRST != 1)
      begin : g_bad_mode
         $error("early_wr_interlock: WRITE_FIRST must be 0 or 1");
      end

   logic [N_DOWN-1:0]             down_live;
   logic [N_DOWN-1:0][REG_AW-1:0] down_dst;
   logic [N_SRC-1:0][REG_AW-1:0]  src_id;
   logic [N_SRC-1:0]              raw_hit;
   logic                          li_en;
   logic                          waw;
   logic                          war;

   always_comb begin
      down_live[SG_RR]  = pending_writer(rr_valid,  rr_we,  rr_ldi);
      down_live[SG_EX]  = pending_writer(ex_valid,  ex_we,  ex_ldi);
      down_live[SG_MEM] = pending_writer(mem_valid, mem_we, mem_ldi);
      down_live[SG_WB]  = pending_writer(wb_valid,  wb_we,  wb_ldi);
      down_dst[SG_RR]   = rr_dst;
      down_dst[SG_EX]   = ex_dst;
      down_dst[SG_MEM]  = mem_dst;
      down_dst[SG_WB]   = wb_dst;
   end

   assign src_id = {rr_src2, rr_src1};
   assign li_en  = id_valid & id_ldi;

   // write-after-write: early writer against every pending later writer
   hz_match #(.AW(REG_AW), .N(N_DOWN)) u_waw (
      .key_en   (li_en),
      .key      (id_dst),
      .ent_live (down_live),
      .ent_id   (down_dst),
      .hit      (waw)
   );

   // read-after-write: each operand against execute, memory, writeback
   for (genvar s = 0; s < N_SRC; s++)
      begin : g_raw
         hz_match #(.AW(REG_AW), .N(N_PROD)) u_raw (
            .key_en   (rr_valid),
            .key      (src_id[s]),
            .ent_live (down_live[N_DOWN-1:1]),
            .ent_id   (down_dst[N_DOWN-1:1]),
            .hit      (raw_hit[s])
         );
      end

   hz_war_sel #(.AW(REG_AW), .WRITE_FIRST(WRITE_FIRST)) u_war (
      .li_en    (li_en),
      .li_dst   (id_dst),
      .rd_valid (rr_valid),
      .rd_src1  (rr_src1),
      .rd_src2  (rr_src2),
      .war      (war)
   );

   logic stall_c;
   logic we_c;

   always_comb begin
      stall_c = waw | war | (|raw_hit);
      we_c    = li_en & ~stall_c;
      if (we_c) begin
         // R8: the early port only opens for an unstalled load-immediate
         a_r8_we_needs_ldi: assert (id_valid && id_ldi && !waw && !war)
            else $error("early write while hazard present");
      end
      if (|raw_hit) begin
         // R5: a read-after-write stall needs a valid reader
         a_r5_raw_needs_reader: assert (rr_valid)
            else $error("read hazard with empty operand stage");
      end
   end

   assign stall    = stall_c;
   assign id_rf_we = we_c;
endmodule

// File: tb/early_wr_interlock_test.sv
module early_wr_interlock_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   typedef struct packed {
      logic          v;
      logic          we;
      logic          ldi;
      logic [AW-1:0] dst;
   } stg_t;

   typedef struct packed {
      logic          id_v;
      logic          id_ldi;
      logic [AW-1:0] id_dst;
      stg_t          rr;
      logic [AW-1:0] s1;
      logic [AW-1:0] s2;
      stg_t          ex;
      stg_t          mem;
      stg_t          wb;
      logic          e_wf;   // expected stall, write-first file
      logic          e_rf;   // expected stall, read-first file
      logic [3:0]    req;
   } vec_t;

   function automatic stg_t st(input logic v, input logic we, input logic ldi, input int d);
      stg_t r;
      r.v = v; r.we = we; r.ldi = ldi; r.dst = AW'(d);
      return r;
   endfunction

   localparam stg_t Z = '0;
   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,5'd0, Z,              5'd0,5'd0, Z,              Z,              Z,              1'b0,1'b0,4'd9}, // R9 idle
      '{1'b1,1'b1,5'd3, Z,              5'd0,5'd0, st(1,1,0,3),    Z,              Z,              1'b1,1'b1,4'd1}, // R1 vs EX
      '{1'b1,1'b1,5'd3, Z,              5'd0,5'd0, Z,              Z,              st(1,1,0,3),    1'b1,1'b1,4'd1}, // R1 vs WB
      '{1'b1,1'b1,5'd3, st(1,1,0,3),    5'd1,5'd2, Z,              Z,              Z,              1'b1,1'b1,4'd1}, // R1 vs RR
      '{1'b1,1'b1,5'd3, Z,              5'd0,5'd0, Z,              st(1,1,1,3),    Z,              1'b0,1'b0,4'd2}, // R2 early producer
      '{1'b1,1'b1,5'd4, st(1,0,0,9),    5'd4,5'd1, Z,              Z,              Z,              1'b1,1'b0,4'd3}, // R3/R4 src1
      '{1'b1,1'b1,5'd4, st(1,0,0,9),    5'd1,5'd4, Z,              Z,              Z,              1'b1,1'b0,4'd3}, // R3/R4 src2
      '{1'b1,1'b1,5'd0, st(1,1,0,0),    5'd0,5'd0, st(1,1,0,0),    Z,              Z,              1'b0,1'b0,4'd6}, // R6 zero dst
      '{1'b1,1'b0,5'd8, st(1,0,0,1),    5'd5,5'd1, st(1,1,0,5),    Z,              Z,              1'b1,1'b1,4'd5}, // R5 EX
      '{1'b0,1'b0,5'd0, st(1,0,0,1),    5'd1,5'd6, Z,              st(1,1,0,6),    Z,              1'b1,1'b1,4'd5}, // R5 MEM
      '{1'b0,1'b0,5'd0, st(1,0,0,1),    5'd7,5'd1, Z,              Z,              st(1,0,0,7),    1'b0,1'b0,4'd7}, // R7 we=0
      '{1'b0,1'b0,5'd0, st(1,0,0,1),    5'd7,5'd1, Z,              Z,              st(0,1,0,7),    1'b0,1'b0,4'd7}, // R7 v=0
      '{1'b0,1'b0,5'd0, st(1,0,0,1),    5'd7,5'd1, st(1,1,1,7),    Z,              Z,              1'b0,1'b0,4'd2}, // R2 raw skip
      '{1'b0,1'b0,5'd0, st(1,0,0,1),    5'd0,5'd1, st(1,1,0,0),    Z,              Z,              1'b0,1'b0,4'd6}, // R6 zero src
      '{1'b1,1'b0,5'd3, Z,              5'd0,5'd0, st(1,1,0,3),    Z,              Z,              1'b0,1'b0,4'd9}, // R9 non-ldi decode
      '{1'b1,1'b1,5'd9, st(0,1,0,9),    5'd9,5'd9, Z,              Z,              Z,              1'b0,1'b0,4'd7}, // R7 empty reader
      '{1'b1,1'b1,5'd2, st(1,1,0,1),    5'd3,5'd4, st(1,1,0,5),    st(1,1,0,6),    st(1,1,0,7),    1'b0,1'b0,4'd8}  // R8 clean write
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          id_valid, id_ldi;
   logic [AW-1:0] id_dst;
   logic          rr_valid, rr_we, rr_ldi;
   logic [AW-1:0] rr_dst, rr_src1, rr_src2;
   logic          ex_valid, ex_we, ex_ldi;
   logic [AW-1:0] ex_dst;
   logic          mem_valid, mem_we, mem_ldi;
   logic [AW-1:0] mem_dst;
   logic          wb_valid, wb_we, wb_ldi;
   logic [AW-1:0] wb_dst;
   logic          stall_wf, we_wf, stall_rf, we_rf;

   early_wr_interlock #(.REG_AW(AW), .WRITE_FIRST(1)) uut (
      .id_valid, .id_ldi, .id_dst,
      .rr_valid, .rr_we, .rr_ldi, .rr_dst, .rr_src1, .rr_src2,
      .ex_valid, .ex_we, .ex_ldi, .ex_dst,
      .mem_valid, .mem_we, .mem_ldi, .mem_dst,
      .wb_valid, .wb_we, .wb_ldi, .wb_dst,
      .stall(stall_wf), .id_rf_we(we_wf)
   );

   early_wr_interlock #(.REG_AW(AW), .WRITE_FIRST(0)) uut_rf (
      .id_valid, .id_ldi, .id_dst,
      .rr_valid, .rr_we, .rr_ldi, .rr_dst, .rr_src1, .rr_src2,
      .ex_valid, .ex_we, .ex_ldi, .ex_dst,
      .mem_valid, .mem_we, .mem_ldi, .mem_dst,
      .wb_valid, .wb_we, .wb_ldi, .wb_dst,
      .stall(stall_rf), .id_rf_we(we_rf)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      id_valid = v.id_v; id_ldi = v.id_ldi; id_dst = v.id_dst;
      {rr_valid, rr_we, rr_ldi, rr_dst} = v.rr;
      rr_src1 = v.s1; rr_src2 = v.s2;
      {ex_valid, ex_we, ex_ldi, ex_dst} = v.ex;
      {mem_valid, mem_we, mem_ldi, mem_dst} = v.mem;
      {wb_valid, wb_we, wb_ldi, wb_dst} = v.wb;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   initial begin
      vec_t idle;
      idle = '0;
      apply(idle);
      @(negedge clk);
      // R9: quiet inputs at start
      chk("R9 start stall", stall_wf, 1'b0);
      chk("R8 start write", we_wf, 1'b0);

      for (int i = 0; i < NV; i++) begin
         step();
         apply(VEC[i]);
         @(negedge clk);
         chk($sformatf("R%0d vec%0d stall write-first", VEC[i].req, i), stall_wf, VEC[i].e_wf);
         chk($sformatf("R%0d vec%0d stall read-first", VEC[i].req, i), stall_rf, VEC[i].e_rf);
         chk($sformatf("R8 vec%0d write-first enable", i), we_wf,
             VEC[i].id_v & VEC[i].id_ldi & ~VEC[i].e_wf);
         chk($sformatf("R8 vec%0d read-first enable", i), we_rf,
             VEC[i].id_v & VEC[i].id_ldi & ~VEC[i].e_rf);
      end

      // R1 sweep: every nonzero register against a pending memory-stage writer
      for (int r = 1; r < 32; r++) begin
         vec_t v;
         v = '0;
         v.id_v = 1'b1; v.id_ldi = 1'b1; v.id_dst = AW'(r);
         v.mem = st(1, 1, 0, r);
         step(); apply(v); @(negedge clk);
         chk($sformatf("R1 sweep r%0d", r), stall_rf, 1'b1);
         v.mem = st(1, 1, 0, r ^ 1);
         step(); apply(v); @(negedge clk);
         chk($sformatf("R9 sweep mismatch r%0d", r), stall_rf, 1'b0);
         chk($sformatf("R8 sweep write r%0d", r), we_rf, 1'b1);
      end

      // R3 and R4: same reader, both orderings, then the reader leaves
      begin
         vec_t v;
         v = '0;
         v.id_v = 1'b1; v.id_ldi = 1'b1; v.id_dst = 5'd17;
         v.rr = st(1, 1, 0, 20); v.s1 = 5'd2; v.s2 = 5'd17;
         step(); apply(v); @(negedge clk);
         chk("R3 war write-first", stall_wf, 1'b1);
         chk("R4 war read-first", stall_rf, 1'b0);
         chk("R4 read-first writes", we_rf, 1'b1);
         v.rr.v = 1'b0;
         step(); apply(v); @(negedge clk);
         chk("R7 reader gone", stall_wf, 1'b0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule